// File: doc/BRIEF.md
# Cache Way Victim Selector

This block holds the replacement history of a set-associative cache with one to four ways and names, for the line currently presented, the way that a refill should overwrite. The cache controller drives the line index each cycle. It raises the access strobe with the hit way on a hit, and it raises the fill strobe in the cycle that it writes a refill into the way shown on `victim`. The victim is a combinational function of the stored history, the presented index and the per-way lock mask. History updates take effect at the next rising clock edge.

Three replacement policies are available through a parameter. The random policy uses one free-running counter for the whole cache. The least-recently-replaced policy keeps one bit per line and is defined only for two ways; any other way count falls back to least-recently-used. The least-recently-used policy stores a compact code of the access order of each line. That code is 1, 3 or 5 bits wide for 2, 3 or 4 ways. The strobes carry no back-pressure: there is no ready signal, and every strobe is consumed in the cycle it is high. Tags, data arrays and the refill path are kept elsewhere.

Top module: `cache_victim_sel`

## Requirements
- R1: After reset, with no ways locked, the victim is way 0 for every line under every policy (the random counter starts at 0).
- R2: With one way, the victim is way 0 whatever the inputs are.
- R3: Random policy: one counter serves the whole cache. It is 1 bit wide for two ways and 2 bits wide for three or four ways, starts at 0 and advances by one on every clock edge after reset. Its value is the candidate way, and a value equal to or above the way count selects way 0.
- R4: Least-recently-replaced policy (two ways): the victim is the way not filled most recently on that line; hits leave it unchanged.
- R5: Least-recently-used policy: the victim is the way of the indexed line whose last access (hit or fill) is oldest, and it follows the presented index in the same cycle. The hit way must name an existing way.
- R6: When a hit and a fill fall in the same cycle on one line, the fill goes into the victim shown in that cycle. Afterwards the filled way is the most recent and the hit way the next most recent.
- R7: A way whose lock bit (bit n for way n) is set is never the victim while an unlocked way exists. Least-recently-used then takes the next oldest way, least-recently-replaced takes the other way, and random takes the next higher way, wrapping modulo the way count.
- R8: With every lock bit set, the victim is the highest way (way count minus one).
- R9: A hit or a fill changes the history of the indexed line only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_idx | input | IDX_W | Line being looked up or updated |
| acc_vld | input | 1 | Hit strobe for the indexed line |
| acc_way | input | 2 | Way that hit |
| fill_vld | input | 1 | Refill strobe; data goes into the way on `victim` |
| lock_mask | input | WAYS | Per-way lock bits of the indexed line |
| victim | output | 2 | Way to evict for the indexed line |

## Verification
The two functions that can coincide are a hit and a refill on the same line in one clock. The history must then take both updates, with the refill applied last, while the refill uses the victim from before the update. The bench provokes this in a directed sequence on a four-way least-recently-used line, where the hit way differs from the victim. It also provokes it many times in a pseudo-random sweep. The victim shown on the following cycle is compared with an age-list model in the bench, and a bound property requires that it is neither the hit way nor the filled way.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

  localparam int POL_RAND = 0;
  localparam int POL_LRR  = 1;
  localparam int POL_LRU  = 2;

  typedef logic [1:0]      way_t;
  typedef way_t [3:0]      order_t;   // entry 0 = oldest
  typedef logic [4:0]      code_t;

  function automatic int fact(input int n);
    int r;
    r = 1;
    for (int i = 2; i <= n; i++) r = r * i;
    return r;
  endfunction

  // history bits per line for a policy / way count
  function automatic int hist_bits(input int ways, input int pol);
    if (pol == POL_LRU) begin
      if (ways == 3) return 3;
      if (ways == 4) return 5;
    end
    return 1;
  endfunction

  // factorial-base code -> age order
  function automatic order_t perm_decode(input code_t code, input int n);
    order_t o;
    logic [3:0] used;
    int rem;
    int wgt;
    int d;
    int k;
    o    = '0;
    used = '0;
    rem  = int'(code);
    for (int i = 0; i < 4; i++) begin
      if (i < n) begin
        wgt = fact(n - 1 - i);
        d   = rem / wgt;
        rem = rem % wgt;
        k   = 0;
        for (int j = 0; j < 4; j++) begin
          if (j < n && !used[j]) begin
            if (k == d) begin
              o[i]    = way_t'(j);
              used[j] = 1'b1;
            end
            k = k + 1;
          end
        end
      end
    end
    return o;
  endfunction

  // age order -> factorial-base code
  function automatic code_t perm_encode(input order_t o, input int n);
    int c;
    int d;
    c = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < n) begin
        d = 0;
        for (int j = 0; j < 4; j++)
          if (j > i && j < n && o[j] < o[i]) d = d + 1;
        c = c + d * fact(n - 1 - i);
      end
    end
    return code_t'(c);
  endfunction

  // move a way to the most-recent slot, keep the rest in order
  function automatic order_t perm_touch(input order_t o, input way_t w, input int n);
    order_t r;
    int k;
    r = o;
    k = 0;
    for (int i = 0; i < 4; i++) begin
      if (i < n && o[i] != w) begin
        r[k] = o[i];
        k    = k + 1;
      end
    end
    r[n - 1] = w;
    return r;
  endfunction

endpackage

// File: rtl/cvs_rand_order.sv
module cvs_rand_order
  import cvs_pkg::*;
#(
  parameter int WAYS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic [WAYS-1:0][1:0]  pref
);
  localparam int CW = (WAYS > 2) ? 2 : 1;

  logic [CW-1:0] cnt;
  int            cand;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // R3: out-of-range counter value maps to way 0; R7: cyclic fallback
  always_comb begin
    cand = (int'(cnt) >= WAYS) ? 0 : int'(cnt);
    for (int i = 0; i < WAYS; i++)
      pref[i] = way_t'((cand + i) % WAYS);
  end

endmodule

// File: rtl/cvs_hist_store.sv
module cvs_hist_store #(
  parameter int LINES = 64,
  parameter int SW    = 5,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic             we,
  input  logic [SW-1:0]    wdata,
  output logic [SW-1:0]    rdata
);
  logic [SW-1:0] mem [LINES];

  // R1: cleared history means identity order, way 0 oldest
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;   // R9: only the indexed line
    end
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/cvs_lru_next.sv
module cvs_lru_next
  import cvs_pkg::*;
#(
  parameter int WAYS = 4,
  localparam int SW  = hist_bits(WAYS, POL_LRU)
) (
  input  logic [SW-1:0] state,
  input  logic          acc_vld,
  input  logic [1:0]    acc_way,
  input  logic          fill_vld,
  input  logic [1:0]    fill_way,
  output logic          we,
  output logic [SW-1:0] nxt
);
  order_t ord;

  // R6: hit applied first, fill last (fill way ends most recent)
  always_comb begin
    ord = perm_decode(code_t'(state), WAYS);
    if (acc_vld)  ord = perm_touch(ord, acc_way, WAYS);
    if (fill_vld) ord = perm_touch(ord, fill_way, WAYS);
    nxt = SW'(perm_encode(ord, WAYS));
    we  = acc_vld | fill_vld;
  end

endmodule

// File: rtl/cvs_victim_pick.sv
module cvs_victim_pick #(
  parameter int WAYS = 4
) (
  input  logic [WAYS-1:0][1:0] pref,
  input  logic [WAYS-1:0]      lock,
  output logic [1:0]           victim
);
  logic [3:0] lk4;
  logic       found;

  assign lk4 = 4'(lock);

  // R7: first unlocked way in preference order; R8: all locked -> last way
  always_comb begin
    victim = 2'(WAYS - 1);
    found  = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!found && !lk4[pref[i]]) begin
        victim = pref[i];
        found  = 1'b1;
      end
    end
  end

endmodule

// File: rtl/cache_victim_sel.sv
module cache_victim_sel
  import cvs_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int LINES  = 64,
  parameter int POLICY = POL_LRU,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] line_idx,
  input  logic             acc_vld,
  input  logic [1:0]       acc_way,
  input  logic             fill_vld,
  input  logic [WAYS-1:0]  lock_mask,
  output logic [1:0]       victim
);
  // replaced-order policy exists only for two ways
  localparam int EP = (POLICY == POL_LRR && WAYS != 2) ? POL_LRU : POLICY;
  localparam int SW = hist_bits(WAYS, EP);

  generate
    if (WAYS == 1) begin : g_dm
      // R2
      assign victim = 2'd0;
    end else begin : g_multi
      logic [WAYS-1:0][1:0] pref;

      if (EP == POL_RAND) begin : g_rand
        cvs_rand_order #(.WAYS(WAYS)) u_ord (
          .clk  (clk),
          .rst_n(rst_n),
          .pref (pref)
        );
      end else begin : g_hist
        logic [SW-1:0] cur;
        logic [SW-1:0] nxt;
        logic          we;

        cvs_hist_store #(.LINES(LINES), .SW(SW)) u_store (
          .clk  (clk),
          .rst_n(rst_n),
          .idx  (line_idx),
          .we   (we),
          .wdata(nxt),
          .rdata(cur)
        );

        if (EP == POL_LRR) begin : g_lrr
          // R4: stored bit names the way filled least recently
          assign pref[0] = {1'b0, cur[0]};
          assign pref[1] = {1'b0, ~cur[0]};
          assign we      = fill_vld;
          assign nxt     = SW'(victim == 2'd0);
        end else begin : g_lru
          // R5
          assign pref = (2 * WAYS)'(perm_decode(code_t'(cur), WAYS));
          cvs_lru_next #(.WAYS(WAYS)) u_next (
            .state   (cur),
            .acc_vld (acc_vld),
            .acc_way (acc_way),
            .fill_vld(fill_vld),
            .fill_way(victim),
            .we      (we),
            .nxt     (nxt)
          );
        end
      end

      cvs_victim_pick #(.WAYS(WAYS)) u_pick (
        .pref  (pref),
        .lock  (lock_mask),
        .victim(victim)
      );
    end
  endgenerate

endmodule

// File: rtl/cvs_checker.sv
module cvs_checker
  import cvs_pkg::*;
#(
  parameter int WAYS   = 4,
  parameter int POLICY = POL_LRU,
  parameter int IDX_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] line_idx,
  input logic             acc_vld,
  input logic [1:0]       acc_way,
  input logic             fill_vld,
  input logic [WAYS-1:0]  lock_mask,
  input logic [1:0]       victim
);
  localparam int EP = (POLICY == POL_LRR && WAYS != 2) ? POL_LRU : POLICY;

  logic       armed;
  logic       all_lk;
  logic [3:0] lk4;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assign all_lk = &lock_mask;
  assign lk4    = 4'(lock_mask);

  // R2
  victim_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(victim) < WAYS);

  // R7
  victim_not_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_lk |-> !lk4[victim]);

  // R8
  all_locked_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_lk |-> victim == 2'(WAYS - 1));

  generate
    if (EP == POL_LRU && WAYS > 1) begin : g_lru
      // R5
      hit_leaves_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && acc_vld && !fill_vld) |=>
          (line_idx != $past(line_idx) || lock_mask != '0 || victim != $past(acc_way)));
      if (WAYS > 2) begin : g_both
        // R6
        hit_and_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (armed && acc_vld && fill_vld) |=>
            (line_idx != $past(line_idx) || lock_mask != '0 ||
             (victim != $past(acc_way) && victim != $past(victim))));
      end
    end
    if (EP == POL_LRR) begin : g_lrr
      // R4
      fill_flips_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && fill_vld) |=>
          (line_idx != $past(line_idx) || lock_mask != '0 || victim != $past(victim)));
    end
    if (EP == POL_RAND && WAYS == 4) begin : g_rnd
      // R3
      counter_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && lock_mask == '0 && $past(lock_mask) == '0) |->
          victim == 2'($past(victim) + 2'd1));
    end
  endgenerate

endmodule

bind cache_victim_sel cvs_checker #(
  .WAYS  (WAYS),
  .POLICY(POLICY),
  .IDX_W (IDX_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_idx (line_idx),
  .acc_vld  (acc_vld),
  .acc_way  (acc_way),
  .fill_vld (fill_vld),
  .lock_mask(lock_mask),
  .victim   (victim)
);

// File: tb/cache_victim_sel_test.sv
module cache_victim_sel_test;
  import cvs_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] idx = '0;
  logic       acc = 1'b0;
  logic       fill = 1'b0;
  logic [1:0] way = '0;
  logic [3:0] lk4 = '0;
  logic [1:0] lk2 = '0;
  logic [2:0] lk3 = '0;
  logic [0:0] lk1 = '0;
  logic [1:0] v4, v2, v3, v1;

  int nchk = 0;
  int nerr = 0;
  int ec = 0;
  int mo [8][4];
  int rr [8];
  int both_line = -1;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  cache_victim_sel #(.WAYS(4), .LINES(8), .POLICY(POL_LRU)) uut (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .acc_vld(acc), .acc_way(way),
    .fill_vld(fill), .lock_mask(lk4), .victim(v4));
  cache_victim_sel #(.WAYS(2), .LINES(8), .POLICY(POL_LRR)) uut_rr (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .acc_vld(acc), .acc_way(way),
    .fill_vld(fill), .lock_mask(lk2), .victim(v2));
  cache_victim_sel #(.WAYS(3), .LINES(8), .POLICY(POL_RAND)) uut_rn (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .acc_vld(acc), .acc_way(way),
    .fill_vld(fill), .lock_mask(lk3), .victim(v3));
  cache_victim_sel #(.WAYS(1), .LINES(8), .POLICY(POL_LRU)) uut_dm (
    .clk(clk), .rst_n(rst_n), .line_idx(idx), .acc_vld(acc), .acc_way(way),
    .fill_vld(fill), .lock_mask(lk1), .victim(v1));

  // counter model for R3: cleared in reset, +1 per edge afterwards
  always @(posedge clk or negedge rst_n)
    if (!rst_n) ec <= 0;
    else        ec <= ec + 1;

  task automatic chk(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int exp_lru(input int l, input logic [3:0] k);
    for (int i = 0; i < 4; i++) if (!k[mo[l][i]]) return mo[l][i];
    return 3;
  endfunction

  function automatic int exp_lrr(input int l, input logic [1:0] k);
    if (!k[rr[l]]) return rr[l];
    if (!k[1 - rr[l]]) return 1 - rr[l];
    return 1;
  endfunction

  function automatic int exp_rnd(input logic [2:0] k);
    int c;
    int w;
    c = ec % 4;
    if (c >= 3) c = 0;
    for (int i = 0; i < 3; i++) begin
      w = (c + i) % 3;
      if (!k[w]) return w;
    end
    return 2;
  endfunction

  task automatic touch(input int l, input int w);
    int t[4];
    int k;
    k = 0;
    for (int i = 0; i < 4; i++)
      if (mo[l][i] != w) begin t[k] = mo[l][i]; k++; end
    t[3] = w;
    for (int i = 0; i < 4; i++) mo[l][i] = t[i];
  endtask

  task automatic check_all(input string forced);
    string t;
    int l;
    l = int'(idx);
    if (forced != "")       t = forced;
    else if (&lk4)          t = "R8";
    else if (|lk4)          t = "R7";
    else if (both_line == l) t = "R6";
    else                    t = "R5";
    chk(t, int'(v4), exp_lru(l, lk4));
    chk((&lk2) ? "R8" : ((|lk2) ? "R7" : "R4"), int'(v2), exp_lrr(l, lk2));
    chk((&lk3) ? "R8" : ((|lk3) ? "R7" : "R3"), int'(v3), exp_rnd(lk3));
    chk("R2", int'(v1), 0);
  endtask

  task automatic step(input int l, input bit a, input int w, input bit f,
                      input logic [3:0] k4, input logic [1:0] k2,
                      input logic [2:0] k3, input logic k1);
    int e4;
    int e2;
    @(negedge clk);
    idx = 3'(l); acc = a; way = 2'(w); fill = f;
    lk4 = k4; lk2 = k2; lk3 = k3; lk1 = k1;
    #1;
    check_all("");
    e4 = exp_lru(l, k4);
    e2 = exp_lrr(l, k2);
    @(posedge clk);
    if (a) touch(l, w);
    if (f) begin touch(l, e4); rr[l] = 1 - e2; end
    both_line = (a && f) ? l : -1;
  endtask

  task automatic peek(input int l, input logic [3:0] k4, input logic [1:0] k2,
                      input logic [2:0] k3, input logic k1, input string tag);
    @(negedge clk);
    idx = 3'(l); acc = 1'b0; fill = 1'b0;
    lk4 = k4; lk2 = k2; lk3 = k3; lk1 = k1;
    #1;
    check_all(tag);
  endtask

  initial begin
    logic [31:0] s;
    for (int l = 0; l < 8; l++) begin
      rr[l] = 0;
      for (int i = 0; i < 4; i++) mo[l][i] = i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state on every line
    for (int l = 0; l < 8; l++) peek(l, 4'h0, 2'h0, 3'h0, 1'b0, "R1");

    // R5 / R9: hits on line 5 leave line 6 alone
    step(5, 1, 0, 0, 4'h0, 2'h0, 3'h0, 1'b0);
    step(5, 1, 1, 0, 4'h0, 2'h0, 3'h0, 1'b0);
    step(5, 1, 2, 0, 4'h0, 2'h0, 3'h0, 1'b0);
    peek(5, 4'h0, 2'h0, 3'h0, 1'b0, "R5");
    peek(6, 4'h0, 2'h0, 3'h0, 1'b0, "R9");

    // R6: hit way 2 and fill (victim 0) in one cycle on line 4
    step(4, 1, 1, 0, 4'h0, 2'h0, 3'h0, 1'b0);
    step(4, 1, 2, 1, 4'h0, 2'h0, 3'h0, 1'b0);
    peek(4, 4'h0, 2'h0, 3'h0, 1'b0, "R6");
    // R7: oldest locked, next oldest chosen
    peek(4, 4'b1000, 2'b10, 3'b010, 1'b0, "R7");
    // R8: all locked
    peek(4, 4'hf, 2'h3, 3'h7, 1'b1, "R8");

    // R4: successive fills alternate on line 2
    step(2, 0, 0, 1, 4'h0, 2'h0, 3'h0, 1'b0);
    step(2, 1, 0, 0, 4'h0, 2'h0, 3'h0, 1'b0);
    step(2, 0, 0, 1, 4'h0, 2'h0, 3'h0, 1'b0);
    peek(2, 4'h0, 2'h0, 3'h0, 1'b0, "");

    // sweep over lines, ways, strobes and lock patterns
    s = 32'h1234_5678;
    for (int n = 0; n < 800; n++) begin
      s = s * 32'd1664525 + 32'd1013904223;
      step(int'(s[2:0]), s[8] | s[9], int'(s[11:10]), s[12],
           (s[20:18] == 3'd0) ? s[27:24] : 4'h0,
           (s[17:15] == 3'd0) ? s[29:28] : 2'h0,
           (s[23:21] == 3'd0) ? {s[31:30], s[14]} : 3'h0,
           s[13] & s[7]);
    end
    peek(0, 4'h0, 2'h0, 3'h0, 1'b0, "");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL timeout all-requirements got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

endmodule